// File: doc/BRIEF.md
# Bit-Serial Multiplier with Per-Column Ones Counters

This block forms the product of two N-bit operands (N = 8 by default) that both arrive one bit per clock. Operand A is fed least significant bit first. Operand B is fed most significant bit first, in the same cycles. Because the two streams run in opposite orders, every bit that arrives can be paired with all the bits of the other operand already held. The whole partial-product matrix is therefore gathered in N input cycles rather than 2N.

Each column of the matrix has a small counter of ones. Each partial-product bit adds to the counter of its column on the cycle the pair is formed. Once the last bit pair has been taken, the column counts are weighted by their column positions and summed into a 2N-bit product. A mode input selects unsigned operation or two's-complement operation. Two's-complement operation uses the Baugh-Wooley correction.

A `start` pulse opens an operation. Every cycle with `bit_valid` high then supplies one bit of each operand. The result appears with a `done` flag and stays until the next `start`.

Top module: `ssmul`

## Requirements
- R1: After `start`, the k-th cycle with `bit_valid` high (k = 0..N-1) carries bit k of A on `a_bit` and bit N-1-k of B on `b_bit`. Exactly N such cycles make one operation.
- R2: With `signed_mode` = 0 at `start`, `product` equals the unsigned product A*B over the full 2N bits.
- R3: With `signed_mode` = 1 at `start`, `product` equals the two's-complement product of A and B, taken modulo 2^(2N).
- R4: `start` clears all column counters, held operand bits and the bit index. An operation that was started earlier, finished or not, has no effect on the next result.
- R5: `done` is low after the clock edge that takes the N-th bit pair. It is high, with the valid product, after the clock edge that follows.
- R6: Once `done` is high, `done` and `product` hold their values until the next `start`. Any `bit_valid`, `a_bit` or `b_bit` activity in that time is ignored.
- R7: Cycles with `bit_valid` low between the bits of an operation are ignored, whatever `a_bit` and `b_bit` carry.
- R8: No column counter ever exceeds N.
- R9: After reset, `done` is 0 and `product` is 0.
- R10: The mode is taken from `signed_mode` at `start`. Changes to `signed_mode` during the operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new operation and clears all state |
| bit_valid | input | 1 | Marks a cycle carrying one bit of each operand |
| a_bit | input | 1 | Operand A bit, least significant first |
| b_bit | input | 1 | Operand B bit, most significant first |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned; sampled at start |
| done | output | 1 | Product valid, held until next start |
| product | output | 2N | Result |

## Verification
Every value of A is paired with a fixed set of B values in both modes. The B set includes zero, one, the sign boundary 127/128/129 and all ones, plus spread values, so both the inverted sign-row terms and the constant corrections are exercised. Signed mismatches on operands with a set top bit expose a wrong inversion or correction. Unsigned mismatches expose pairs that are miscounted or counted twice. Separate runs insert idle cycles carrying garbage bits and a flipped mode, restart in the middle of an operation, and drive bits after `done`. These runs separate gating and clearing faults from arithmetic faults.

// File: rtl/ssmul.sv
module ssmul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           bit_valid,
  input  logic           a_bit,
  input  logic           b_bit,
  input  logic           signed_mode,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int PW = 2 * N;
  localparam int NC = 2 * N - 1;
  localparam int CW = $clog2(N + 1);
  localparam int TW = $clog2(N + 1);

  logic [CW-1:0] col [NC];
  logic [N-1:0]  a_hold, b_hold;
  logic [TW-1:0] idx;
  logic          busy, fin, sgn;
  logic [NC-1:0] hit;
  logic [PW-1:0] total;

  wire take = busy & bit_valid & ~start;
  wire last = (idx == TW'(N - 1));

  always_comb begin
    hit = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if ((i == int'(idx) && j >= N - 1 - int'(idx)) || (j == N - 1 - int'(idx) && i < int'(idx)))
          hit[i+j] = (((i == int'(idx)) ? a_bit : a_hold[i]) & ((j == N - 1 - int'(idx)) ? b_bit : b_hold[j]))
                     ^ (sgn & ((i == N - 1) != (j == N - 1)));
  end

  always_comb begin
    total = '0;
    if (sgn) total = (PW'(1) << N) + (PW'(1) << (PW - 1));
    for (int k = 0; k < NC; k++) total = total + (PW'(col[k]) << k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++) col[k] <= '0;
      a_hold <= '0; b_hold <= '0; idx <= '0;
      busy <= 1'b0; fin <= 1'b0; sgn <= 1'b0;
      done <= 1'b0; product <= '0;
    end else if (start) begin
      for (int k = 0; k < NC; k++) col[k] <= '0;
      a_hold <= '0; b_hold <= '0; idx <= '0;
      busy <= 1'b1; fin <= 1'b0; sgn <= signed_mode;
      done <= 1'b0; product <= '0;
    end else begin
      fin <= 1'b0;
      if (take) begin
        for (int k = 0; k < NC; k++) col[k] <= col[k] + CW'(hit[k]);
        a_hold[int'(idx)] <= a_bit;
        b_hold[N-1-int'(idx)] <= b_bit;
        idx <= idx + TW'(1);
        if (last) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
      if (fin) begin
        product <= total;
        done    <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_colchk
    p_col_bound_r8: assert property (@(posedge clk) disable iff (!rst_n) col[k] <= CW'(N));
  end

  p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && idx == '0 && busy));
  p_last_to_fin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (start || (fin && !done)));
  p_fin_to_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> done);
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product)));
  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !start) |=> ($stable(idx) && $stable(a_hold) && $stable(b_hold)));
  p_mode_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sgn));
endmodule

// File: tb/ssmul_test.sv
`timescale 1ns/1ps
module ssmul_test;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bit_valid = 1'b0;
  logic a_bit = 1'b0, b_bit = 1'b0, signed_mode = 1'b0;
  logic done;
  logic [2*N-1:0] product;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ssmul #(.N(N)) uut (.clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .a_bit(a_bit), .b_bit(b_bit), .signed_mode(signed_mode), .done(done), .product(product));

  task automatic check(string req, logic [2*N-1:0] got, logic [2*N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2*N-1:0] expect_prod(logic [N-1:0] a, logic [N-1:0] b, logic m);
    logic signed [2*N-1:0] sa, sb;
    if (!m) return {{N{1'b0}}, a} * {{N{1'b0}}, b};
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    return sa * sb;
  endfunction

  function automatic logic [N-1:0] b_pick(int k);
    case (k)
      0: return 8'd0;   1: return 8'd1;   2: return 8'd2;   3: return 8'd127;
      4: return 8'd128; 5: return 8'd129; 6: return 8'd254; 7: return 8'd255;
      default: return 8'((k * 37 + 11) ^ (k << 4));
    endcase
  endfunction

  task automatic open_op(logic m);
    @(negedge clk); start = 1'b1; signed_mode = m; bit_valid = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic feed(logic [N-1:0] a, logic [N-1:0] b, logic m, bit gaps, int upto);
    for (int t = 0; t < upto; t++) begin
      if (gaps && (t % 3 == 1)) begin
        bit_valid = 1'b0; a_bit = ~a[t]; b_bit = ~b[N-1-t]; signed_mode = ~m;
        @(negedge clk);
        bit_valid = 1'b0; a_bit = 1'b1; b_bit = 1'b1;
        @(negedge clk);
      end
      bit_valid = 1'b1; a_bit = a[t]; b_bit = b[N-1-t];
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, logic m, bit gaps, string req);
    open_op(m);
    feed(a, b, m, gaps, N);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R5: done early got %b expected 0", done);
    end
    @(negedge clk);
    check("R5 done", {{(2*N-1){1'b0}}, done}, 1);
    check(req, product, expect_prod(a, b, m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2*N-1:0] held;
    repeat (3) @(negedge clk);
    // R9: reset values while reset is still applied and right after it lifts
    check("R9 done", {{(2*N-1){1'b0}}, done}, 0);
    check("R9 product", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 done after release", {{(2*N-1){1'b0}}, done}, 0);

    // R1, R2, R3: sweep of all A against a set of B values in both modes
    for (int m = 0; m < 2; m++)
      for (int bi = 0; bi < 20; bi++)
        for (int a = 0; a < 256; a++)
          run_op(8'(a), b_pick(bi), 1'(m), 1'b0, m ? "R3 signed" : "R2 unsigned");

    // R7, R10: idle cycles carrying garbage bits and a flipped mode
    run_op(8'hA5, 8'h9C, 1'b1, 1'b1, "R7 R10 gaps signed");
    run_op(8'hFF, 8'h81, 1'b0, 1'b1, "R7 R10 gaps unsigned");
    run_op(8'h80, 8'h80, 1'b1, 1'b1, "R7 R10 gaps corners");

    // R6: bits driven after done are ignored
    held = product;
    for (int t = 0; t < 6; t++) begin
      bit_valid = 1'b1; a_bit = 1'(t); b_bit = ~a_bit;
      @(negedge clk);
    end
    bit_valid = 1'b0;
    check("R6 product held", product, held);
    check("R6 done held", {{(2*N-1){1'b0}}, done}, 1);

    // R4: restart in mid-operation, then a fresh result must not be polluted
    open_op(1'b0);
    feed(8'hFF, 8'hFF, 1'b0, 1'b0, 5);
    check("R4 no done mid-op", {{(2*N-1){1'b0}}, done}, 0);
    run_op(8'h03, 8'h05, 1'b0, 1'b0, "R4 restart");
    run_op(8'h7F, 8'hFF, 1'b1, 1'b0, "R4 after full op");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule